// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up-counter made of 4-bit stages that can be chained into one wide counter. Every state bit is clocked by the same rising edge, so all outputs move together and no bit waits on another bit's clock. The counter can be preset from a parallel data input. It can be cleared either asynchronously or on the next clock edge; a parameter picks the clear mode.

Two count enables control counting, and both must be high. The "T" enable also qualifies the carry output. Inside the wrapper, each stage's carry drives the T input of the stage above it, and the P enable goes to every stage. The chain therefore counts as a single binary counter of width 4 × stage count, with no extra gating between stages.

In synchronous clear mode, a shortened count cycle is easy to build. Decode the wanted terminal value outside the block and feed it back to the clear input. The counter then returns to zero on the edge after the terminal value.

Top module: `cnt_chain`

## Requirements
- R1: With clear and load inactive and both enables high, the combined output increases by exactly one on each rising clock edge, and carries propagate across stages as one counter.
- R2: When the combined output is all ones and counting is enabled, the next rising edge wraps the output to zero.
- R3: With clear inactive and load low, the next rising edge copies the data input to the output, whatever the enable levels are.
- R4: With clear and load inactive and either enable low, the output keeps its value across the edge.
- R5: The carry output is high exactly when the T enable is high and the combined output is all ones. The P enable has no effect on it.
- R6: In asynchronous clear mode, a low clear forces the output to zero at once, without a clock edge, and keeps it there over load and enables.
- R7: In synchronous clear mode, a low clear leaves the output unchanged until the next rising edge. That edge sets it to zero, overriding a simultaneous load.
- R8: Changes on load, P or T between edges leave the output unchanged until the next rising edge.
- R9: In synchronous clear mode, feeding back a decode of value 9 to the clear input makes the counter step 0,1,...,9,0 repeatedly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all state bits |
| clr_n | input | 1 | Active-low clear (asynchronous or synchronous per parameter) |
| load_n | input | 1 | Active-low parallel preset |
| din | input | STAGES*STAGE_W | Preset data |
| en_p | input | 1 | Count enable shared by all stages |
| en_t | input | 1 | Count enable that also qualifies the carry |
| q | output | STAGES*STAGE_W | Combined count value |
| carry_out | output | 1 | High when en_t is high and q is all ones |

## Verification
The two functions that can meet in one cycle are clear and load, and also load and count. The bench drives clear low together with load low and both enables high, and in the same edge drives load low with both enables high. The result must be zero in the first case and the preset data in the second. In asynchronous mode, clear is dropped halfway through a clock cycle, and the output is checked before the next edge. In synchronous mode, the output must keep its old value until the edge and be zero after it. A reference model in the bench follows the same priority order and judges every cycle of a long pseudo-random stimulus run.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;

  // Priority: clear, then load, then count, then hold.
  function automatic cnt_op_e cnt_pick_op(input logic sync_clr,
                                          input logic load_n,
                                          input logic en_p,
                                          input logic en_t);
    if (sync_clr)          return OP_CLEAR;
    else if (!load_n)      return OP_LOAD;
    else if (en_p && en_t) return OP_COUNT;
    else                   return OP_HOLD;
  endfunction

endpackage

// File: rtl/cnt_term.sv
module cnt_term #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             en_t,
  output logic             full,
  output logic             carry
);
  assign full  = &q;
  assign carry = en_t & full;
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cnt_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             en_p,
  input  logic             en_t,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic             carry
);

  function automatic logic [WIDTH-1:0] apply_op(input cnt_op_e op,
                                                input logic [WIDTH-1:0] cur,
                                                input logic [WIDTH-1:0] data);
    case (op)
      OP_CLEAR: return '0;
      OP_LOAD:  return data;
      OP_COUNT: return cur + 1'b1;
      default:  return cur;
    endcase
  endfunction

  logic [WIDTH-1:0] q_r;
  logic [WIDTH-1:0] q_nxt;
  logic             sync_clr_req;
  logic             full;
  cnt_op_e          op;

  // named events for the assertions
  logic ev_load, ev_count, ev_hold, ev_wrap;

  assign sync_clr_req = (ASYNC_CLR == 1'b0) && !clr_n;
  assign op           = cnt_pick_op(sync_clr_req, load_n, en_p, en_t);
  assign q_nxt        = apply_op(op, q_r, d);

  assign ev_load  = clr_n && !load_n;
  assign ev_count = clr_n && load_n && en_p && en_t;
  assign ev_hold  = clr_n && load_n && !(en_p && en_t);
  assign ev_wrap  = ev_count && full;

  cnt_term #(.WIDTH(WIDTH)) u_term (
    .q     (q_r),
    .en_t  (en_t),
    .full  (full),
    .carry (carry)
  );

  generate
    if (ASYNC_CLR) begin : g_async_clr
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q_r <= '0;
        else        q_r <= q_nxt;
      end
      // R6
      async_clr_chk: assert property (@(posedge clk) !clr_n |-> q_r == '0);
    end else begin : g_sync_clr
      always_ff @(posedge clk) begin
        q_r <= q_nxt;
      end
      // R7
      sync_clr_chk: assert property (@(posedge clk) !clr_n |=> q_r == '0);
    end
  endgenerate

  assign q = q_r;

  // R3
  load_copy_chk: assert property (@(posedge clk) disable iff (!clr_n)
    ev_load |=> q_r == $past(d));
  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!clr_n)
    ev_count |=> q_r == $past(q_r) + 1'b1);
  // R2
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!clr_n)
    ev_wrap |=> q_r == '0);
  // R4
  hold_value_chk: assert property (@(posedge clk) disable iff (!clr_n)
    ev_hold |=> $stable(q_r));

endmodule

// File: rtl/cnt_chain.sv
module cnt_chain #(
  parameter int STAGES    = 2,
  parameter int STAGE_W   = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic                        clk,
  input  logic                        clr_n,
  input  logic                        load_n,
  input  logic [STAGES*STAGE_W-1:0]   din,
  input  logic                        en_p,
  input  logic                        en_t,
  output logic [STAGES*STAGE_W-1:0]   q,
  output logic                        carry_out
);
  localparam int TOTAL_W = STAGES * STAGE_W;

  // t_link[k] is the T enable of stage k; t_link[k+1] is its carry
  logic [STAGES:0] t_link;
  assign t_link[0] = en_t;

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      cnt_stage #(
        .WIDTH     (STAGE_W),
        .ASYNC_CLR (ASYNC_CLR)
      ) u_stage (
        .clk    (clk),
        .clr_n  (clr_n),
        .load_n (load_n),
        .en_p   (en_p),
        .en_t   (t_link[k]),
        .d      (din[k*STAGE_W +: STAGE_W]),
        .q      (q[k*STAGE_W +: STAGE_W]),
        .carry  (t_link[k+1])
      );
    end
  endgenerate

  assign carry_out = t_link[STAGES];

  // R5
  carry_full_chk: assert property (@(posedge clk) disable iff (!clr_n)
    carry_out |-> q == {TOTAL_W{1'b1}});
  // R5
  carry_t_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !en_t |-> !carry_out);
  // R1
  wide_count_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_p && en_t) |=> q == $past(q) + 1'b1);

endmodule

// File: tb/cnt_chain_tb.sv
module cnt_chain_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         clr_n = 1'b1;
  logic         clr_s_drv = 1'b0;
  logic         mod10_on = 1'b0;
  logic         load_n = 1'b1;
  logic         en_p = 1'b0;
  logic         en_t = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] q, qs;
  logic         carry_out, carry_s;
  logic         clr_s_n;

  int n_chk = 0;
  int n_err = 0;
  logic [W-1:0] expv = '0;
  logic [W-1:0] exps = '0;
  logic [15:0]  lf = 16'hACE1;

  always #5 clk = ~clk;

  // external terminal decode for the modulo-10 count
  assign clr_s_n = mod10_on ? !(qs == 8'd9) : clr_s_drv;

  cnt_chain #(.STAGES(2), .STAGE_W(4), .ASYNC_CLR(1'b1)) dut_i (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
    .en_p(en_p), .en_t(en_t), .q(q), .carry_out(carry_out));

  cnt_chain #(.STAGES(2), .STAGE_W(4), .ASYNC_CLR(1'b0)) dut_s (
    .clk(clk), .clr_n(clr_s_n), .load_n(load_n), .din(din),
    .en_p(en_p), .en_t(en_t), .q(qs), .carry_out(carry_s));

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  // one cycle on the asynchronous-clear instance against the model
  task automatic cycle(input logic c, input logic l, input logic p,
                       input logic t, input logic [W-1:0] d);
    string tag;
    @(negedge clk);
    clr_n = c; load_n = l; en_p = p; en_t = t; din = d;
    #1;
    if (!c) expv = '0;
    chk(c ? "R8 no change before edge" : "R6 immediate clear", q, expv);
    chk("R5 carry", {7'd0, carry_out}, {7'd0, (t && expv == 8'hFF)});
    if (!c)          tag = "R6 clear overrides";
    else if (!l)     tag = "R3 load";
    else if (p && t) tag = (expv == 8'hFF) ? "R2 wrap" : "R1 count";
    else             tag = "R4 hold";
    @(posedge clk);
    if (!c)          expv = '0;
    else if (!l)     expv = d;
    else if (p && t) expv = expv + 8'd1;
    #1;
    chk(tag, q, expv);
  endtask

  initial begin
    #2 clr_n = 1'b0;
    #1 chk("R6 reset", q, 8'h00);
    @(posedge clk); #1;
    chk("R7 reset", qs, 8'h00);
    @(negedge clk); clr_s_drv = 1'b1;

    cycle(1, 0, 0, 0, 8'hF0);        // load with enables low
    cycle(1, 1, 1, 0, 8'h00);        // hold, T low
    cycle(1, 1, 0, 1, 8'h00);        // hold, P low
    cycle(1, 0, 1, 1, 8'hFD);        // load beats count
    cycle(1, 1, 1, 1, 8'h00);
    cycle(1, 1, 1, 1, 8'h00);        // reaches FF
    cycle(1, 1, 0, 1, 8'h00);        // carry high with P low
    cycle(1, 1, 1, 0, 8'h00);        // carry low with T low
    cycle(1, 1, 1, 1, 8'h00);        // wrap
    cycle(1, 0, 0, 0, 8'h0F);
    cycle(1, 1, 1, 1, 8'h00);        // carry across stages 0F->10
    cycle(1, 0, 0, 0, 8'h77);
    cycle(0, 0, 1, 1, 8'hAA);        // mid-cycle clear with load and count
    cycle(1, 1, 1, 1, 8'h00);

    for (int i = 0; i < 1500; i++) begin
      logic c, l, p, t;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      c = (lf[4:0] != 5'd0);
      l = (lf[7:5] != 3'd0);
      p = (lf[9:8] != 2'd0);
      t = (lf[11:10] != 2'd0);
      cycle(c, l, p, t, {lf[15:12], lf[3:0]} | ((lf[6:5] == 2'd3) ? 8'hF8 : 8'h00));
    end

    // synchronous clear: no effect before the edge, wins over load
    cycle(1, 0, 0, 0, 8'h5A);
    @(negedge clk);
    clr_s_drv = 1'b0; load_n = 1'b0; din = 8'h33; en_p = 1'b1; en_t = 1'b1;
    #1 chk("R7 no clear before edge", qs, 8'h5A);
    @(posedge clk); #1;
    chk("R7 clear on edge", qs, 8'h00);

    // modulo-10 via fed-back terminal decode
    @(negedge clk);
    clr_s_drv = 1'b1; mod10_on = 1'b1; load_n = 1'b1; en_p = 1'b1; en_t = 1'b1;
    exps = 8'h00;
    for (int i = 0; i < 25; i++) begin
      @(posedge clk);
      exps = (exps == 8'd9) ? 8'd0 : exps + 8'd1;
      #1 chk("R9 modulo-10", qs, exps);
    end

    report();
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=running expected=done");
    report();
    $finish;
  end

endmodule